// File: doc/BRIEF.md
# Translation entry store with word-select write port

This block is the storage array of an address-translation buffer. It holds a parameterised number of entries (64 by default). Each entry is split into three words: a tag word (page number, valid, address-space bit, size code and a captured search ID), a real-address word (real page number and its extension), and an attribute word (storage attributes and access permissions). A privileged write replaces exactly one of these words. The source register supplies the data, and a 2-bit word-select code chooses which word. Only the low bits of a 32-bit index operand select the entry.

For every word written, a single even-parity bit is computed in hardware from the data bits actually stored. Source bits that fall outside the stored fields are discarded, including the positions where software might place parity. A combinational read port returns any word of any entry with its fields in their source bit positions, and it flags any mismatch between the stored parity and the recomputed parity. A test input inverts a stored parity bit so that this checking path can be exercised. A write in user mode, or a write with the reserved word-select code, leaves the array untouched and raises a one-cycle flag instead.

Top module: `xlat_entry_store`

## Requirements
- R1: The entry written is selected by `wr_ixop_i[5:0]` (big-endian bits 26 to 31). Bits `wr_ixop_i[31:6]` have no effect.
- R2: Word select 0 stores `wr_src_i[31:4]` (page number [31:10], valid [9], space [8], size [7:4]) and captures `stid_i` as the entry's search ID. A read of word 0 returns these bits in the same positions, zero in [3:0], and the ID on `rd_tid_o`.
- R3: Word select 1 stores `wr_src_i[31:10]` (real page) and `wr_src_i[3:0]` (extended real page). Source bits [9:4] are discarded and read back as zero.
- R4: Word select 2 stores `wr_src_i[15:7]` (nine attribute bits) and `wr_src_i[5:0]` (six permission bits). All other bits are discarded and read back as zero.
- R5: A write changes only the selected word of the selected entry. The other two words of that entry, and all other entries, keep their contents. With no write and no parity flip, the read outputs for a fixed read address stay stable.
- R6: A privileged write with word select 3 changes no entry. It drives `bad_form_o` high in the next cycle only. A read with word select 3 returns zero data, zero ID and no parity error.
- R7: A write with `priv_i` low changes no entry. It drives `priv_fault_o` high in the next cycle only, and `bad_form_o` stays low.
- R8: Parity for each word is even over its stored data bits. For word 0 the parity also covers the captured ID. `rd_perr_o` is low for every word last written through the write port, whatever the source bits outside the fields were.
- R9: A write performed at a clock edge is visible on the read port in the cycle that follows.
- R10: `par_flip_i` inverts the stored parity bit of the word addressed by the read port. `rd_perr_o` then stays high for that word until it is written again. A flip is ignored when the same cycle writes that entry, or when the read select is 3.
- R11: After reset every word of every entry reads as zero with no parity error, and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write request for this cycle |
| priv_i | input | 1 | Privileged mode when high |
| wr_wsel_i | input | 2 | Word select of the write |
| wr_ixop_i | input | 32 | Index operand; the low bits pick the entry |
| wr_src_i | input | 32 | Source register value |
| stid_i | input | TID_W | Search ID from the control register |
| rd_idx_i | input | IDX_W | Read entry index |
| rd_wsel_i | input | 2 | Read word select |
| rd_data_o | output | 32 | Stored fields in source bit positions |
| rd_tid_o | output | TID_W | Captured search ID (word 0 only) |
| rd_perr_o | output | 1 | Parity mismatch on the read word |
| bad_form_o | output | 1 | Reserved word-select write seen last cycle |
| priv_fault_o | output | 1 | User-mode write attempt seen last cycle |
| par_flip_i | input | 1 | Test hook: invert parity of the read-addressed word |

## Verification
The bench builds the block with its default parameters: 64 entries and an 8-bit search ID. This makes the full index range reachable, including entries 0 and 63, and lets index operands with upper bits set show that only the low six bits decode. Several thousand mixed cycles of writes, user-mode attempts, reserved-select writes, parity flips and reads of random words are compared against the model every cycle. This covers same-entry collisions between a write and a flip, and rewrites that clear a flipped parity bit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int XW    = 32;
  localparam int W0_DW = 28;
  localparam int W1_DW = 26;
  localparam int W2_DW = 15;

  typedef enum logic [1:0] {
    WS_TAG  = 2'd0,
    WS_REAL = 2'd1,
    WS_ATTR = 2'd2,
    WS_BAD  = 2'd3
  } wsel_e;

  typedef struct packed {
    logic [W0_DW-1:0] d;
    logic             p;
  } w0_t;

  typedef struct packed {
    logic [W1_DW-1:0] d;
    logic             p;
  } w1_t;

  typedef struct packed {
    logic [W2_DW-1:0] d;
    logic             p;
  } w2_t;
endpackage

// File: rtl/xlat_par_gen.sv
module xlat_par_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  output logic         p_o
);
  generate
    if (W == 1) begin : g_one
      assign p_o = d_i[0];
    end else begin : g_tree
      localparam int H = W / 2;
      logic lo_p, hi_p;
      xlat_par_gen #(.W(H))     u_lo (.d_i(d_i[H-1:0]), .p_o(lo_p));
      xlat_par_gen #(.W(W - H)) u_hi (.d_i(d_i[W-1:H]), .p_o(hi_p));
      assign p_o = lo_p ^ hi_p;
    end
  endgenerate
endmodule

// File: rtl/xlat_wr_fmt.sv
module xlat_wr_fmt
  import xlat_pkg::*;
#(
  parameter int TID_W = 8
) (
  input  logic [XW-1:0]    src_i,
  input  logic [TID_W-1:0] stid_i,
  output w0_t              w0_o,
  output w1_t              w1_o,
  output w2_t              w2_o
);
  logic [W0_DW-1:0] d0;
  logic [W1_DW-1:0] d1;
  logic [W2_DW-1:0] d2;
  logic             p0, p1, p2;

  // field remap: only stored bits feed parity
  assign d0 = src_i[31:4];
  assign d1 = {src_i[31:10], src_i[3:0]};
  assign d2 = {src_i[15:7], src_i[5:0]};

  xlat_par_gen #(.W(W0_DW + TID_W)) u_p0 (.d_i({d0, stid_i}), .p_o(p0));
  xlat_par_gen #(.W(W1_DW))         u_p1 (.d_i(d1),           .p_o(p1));
  xlat_par_gen #(.W(W2_DW))         u_p2 (.d_i(d2),           .p_o(p2));

  assign w0_o = '{d: d0, p: p0};
  assign w1_o = '{d: d1, p: p1};
  assign w2_o = '{d: d2, p: p2};
endmodule

// File: rtl/xlat_rd_pack.sv
module xlat_rd_pack
  import xlat_pkg::*;
#(
  parameter int TID_W = 8
) (
  input  logic [1:0]       wsel_i,
  input  w0_t              w0_i,
  input  w1_t              w1_i,
  input  w2_t              w2_i,
  input  logic [TID_W-1:0] tid_i,
  output logic [XW-1:0]    data_o,
  output logic [TID_W-1:0] tid_o,
  output logic             perr_o
);
  logic c0, c1, c2;

  xlat_par_gen #(.W(W0_DW + TID_W)) u_c0 (.d_i({w0_i.d, tid_i}), .p_o(c0));
  xlat_par_gen #(.W(W1_DW))         u_c1 (.d_i(w1_i.d),          .p_o(c1));
  xlat_par_gen #(.W(W2_DW))         u_c2 (.d_i(w2_i.d),          .p_o(c2));

  always_comb begin
    data_o = '0;
    tid_o  = '0;
    perr_o = 1'b0;
    unique case (wsel_e'(wsel_i))
      WS_TAG: begin
        data_o = {w0_i.d, 4'b0000};
        tid_o  = tid_i;
        perr_o = c0 ^ w0_i.p;
      end
      WS_REAL: begin
        data_o = {w1_i.d[25:4], 6'b000000, w1_i.d[3:0]};
        perr_o = c1 ^ w1_i.p;
      end
      WS_ATTR: begin
        data_o = {16'h0000, w2_i.d[14:6], 1'b0, w2_i.d[5:0]};
        perr_o = c2 ^ w2_i.p;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xlat_entry_store.sv
module xlat_entry_store
  import xlat_pkg::*;
#(
  parameter  int N_ENT = 64,
  parameter  int TID_W = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             priv_i,
  input  logic [1:0]       wr_wsel_i,
  input  logic [XW-1:0]    wr_ixop_i,
  input  logic [XW-1:0]    wr_src_i,
  input  logic [TID_W-1:0] stid_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [1:0]       rd_wsel_i,
  output logic [XW-1:0]    rd_data_o,
  output logic [TID_W-1:0] rd_tid_o,
  output logic             rd_perr_o,
  output logic             bad_form_o,
  output logic             priv_fault_o,
  input  logic             par_flip_i
);
  w0_t              w0_q  [N_ENT];
  w1_t              w1_q  [N_ENT];
  w2_t              w2_q  [N_ENT];
  logic [TID_W-1:0] tid_q [N_ENT];

  w0_t              nw0;
  w1_t              nw1;
  w2_t              nw2;
  logic [IDX_W-1:0] wr_idx;
  wsel_e            ws, rws;
  logic             wr_go;

  assign wr_idx = wr_ixop_i[IDX_W-1:0];
  assign ws     = wsel_e'(wr_wsel_i);
  assign rws    = wsel_e'(rd_wsel_i);
  assign wr_go  = wr_en_i & priv_i & (ws != WS_BAD);

  xlat_wr_fmt #(.TID_W(TID_W)) u_fmt (
    .src_i (wr_src_i),
    .stid_i(stid_i),
    .w0_o  (nw0),
    .w1_o  (nw1),
    .w2_o  (nw2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_ENT; e++) begin
        w0_q[e]  <= '0;
        w1_q[e]  <= '0;
        w2_q[e]  <= '0;
        tid_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < N_ENT; e++) begin
        if (wr_go && wr_idx == IDX_W'(e)) begin
          unique case (ws)
            WS_TAG: begin
              w0_q[e]  <= nw0;
              tid_q[e] <= stid_i;
            end
            WS_REAL: w1_q[e] <= nw1;
            WS_ATTR: w2_q[e] <= nw2;
            default: ;
          endcase
        end else if (par_flip_i && rd_idx_i == IDX_W'(e)) begin
          // test hook: corrupt stored parity only
          unique case (rws)
            WS_TAG:  w0_q[e].p <= ~w0_q[e].p;
            WS_REAL: w1_q[e].p <= ~w1_q[e].p;
            WS_ATTR: w2_q[e].p <= ~w2_q[e].p;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_fault_o <= 1'b0;
      bad_form_o   <= 1'b0;
    end else begin
      priv_fault_o <= wr_en_i & ~priv_i;
      bad_form_o   <= wr_en_i & priv_i & (ws == WS_BAD);
    end
  end

  xlat_rd_pack #(.TID_W(TID_W)) u_rd (
    .wsel_i(rd_wsel_i),
    .w0_i  (w0_q[rd_idx_i]),
    .w1_i  (w1_q[rd_idx_i]),
    .w2_i  (w2_q[rd_idx_i]),
    .tid_i (tid_q[rd_idx_i]),
    .data_o(rd_data_o),
    .tid_o (rd_tid_o),
    .perr_o(rd_perr_o)
  );
endmodule

// File: rtl/xlat_entry_store_chk.sv
module xlat_entry_store_chk #(
  parameter int IDX_W = 6,
  parameter int TID_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             priv_i,
  input logic [1:0]       wr_wsel_i,
  input logic [31:0]      wr_ixop_i,
  input logic [31:0]      wr_src_i,
  input logic [TID_W-1:0] stid_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic [1:0]       rd_wsel_i,
  input logic [31:0]      rd_data_o,
  input logic [TID_W-1:0] rd_tid_o,
  input logic             rd_perr_o,
  input logic             bad_form_o,
  input logic             priv_fault_o,
  input logic             par_flip_i
);
  assert_priv_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !priv_i) |=> (priv_fault_o && !bad_form_o));

  assert_bad_form_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && priv_i && wr_wsel_i == 2'd3) |=> (bad_form_o && !priv_fault_o));

  assert_flags_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (!bad_form_o && !priv_fault_o));

  assert_rsvd_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_wsel_i == 2'd3) |-> (rd_data_o == 32'h0 && rd_tid_o == '0 && !rd_perr_o));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) && !$past(par_flip_i) && $stable(rd_idx_i) && $stable(rd_wsel_i))
    |-> ($stable(rd_data_o) && $stable(rd_tid_o) && $stable(rd_perr_o)));

  // tag word written last cycle is read back with clean parity (R8)
  assert_tag_visible_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i && priv_i && wr_wsel_i == 2'd0) && rd_wsel_i == 2'd0 &&
     rd_idx_i == $past(wr_ixop_i[IDX_W-1:0]))
    |-> (rd_data_o[31:4] == $past(wr_src_i[31:4]) && rd_tid_o == $past(stid_i) && !rd_perr_o));
endmodule

bind xlat_entry_store xlat_entry_store_chk #(.IDX_W(IDX_W), .TID_W(TID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .priv_i      (priv_i),
  .wr_wsel_i   (wr_wsel_i),
  .wr_ixop_i   (wr_ixop_i),
  .wr_src_i    (wr_src_i),
  .stid_i      (stid_i),
  .rd_idx_i    (rd_idx_i),
  .rd_wsel_i   (rd_wsel_i),
  .rd_data_o   (rd_data_o),
  .rd_tid_o    (rd_tid_o),
  .rd_perr_o   (rd_perr_o),
  .bad_form_o  (bad_form_o),
  .priv_fault_o(priv_fault_o),
  .par_flip_i  (par_flip_i)
);

// File: tb/xlat_entry_store_tb.sv
module xlat_entry_store_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 64;
  localparam int TW  = 8;
  localparam logic [31:0] MASK0 = 32'hFFFF_FFF0;
  localparam logic [31:0] MASK1 = 32'hFFFF_FC0F;
  localparam logic [31:0] MASK2 = 32'h0000_FFBF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, priv = 1'b0, flip = 1'b0;
  logic [1:0]    wr_ws = '0, rd_ws = '0;
  logic [31:0]   ixop = '0, src = '0;
  logic [TW-1:0] stid = '0;
  logic [5:0]    rd_idx = '0;
  logic [31:0]   rd_data;
  logic [TW-1:0] rd_tid;
  logic          rd_perr, bad_form, priv_fault;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R11";

  logic [31:0]   m_word [N][3];
  logic [TW-1:0] m_tid  [N];
  logic          m_bad  [N][3];
  logic          e_pf, e_bf;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_entry_store u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .priv_i(priv),
    .wr_wsel_i(wr_ws), .wr_ixop_i(ixop), .wr_src_i(src), .stid_i(stid),
    .rd_idx_i(rd_idx), .rd_wsel_i(rd_ws), .rd_data_o(rd_data), .rd_tid_o(rd_tid),
    .rd_perr_o(rd_perr), .bad_form_o(bad_form), .priv_fault_o(priv_fault),
    .par_flip_i(flip)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N; e++) begin
        m_tid[e] = '0;
        for (int w = 0; w < 3; w++) begin m_word[e][w] = '0; m_bad[e][w] = 1'b0; end
      end
      e_pf = 1'b0;
      e_bf = 1'b0;
    end else begin
      automatic int wi = int'(ixop[5:0]);
      automatic bit go = wr_en && priv && wr_ws != 2'd3;
      e_pf = wr_en && !priv;
      e_bf = wr_en && priv && wr_ws == 2'd3;
      if (go) begin
        case (wr_ws)
          2'd0: begin m_word[wi][0] = src & MASK0; m_tid[wi] = stid; end
          2'd1: m_word[wi][1] = src & MASK1;
          default: m_word[wi][2] = src & MASK2;
        endcase
        m_bad[wi][wr_ws] = 1'b0;
      end
      if (flip && rd_ws != 2'd3 && !(go && wi == int'(rd_idx)))
        m_bad[rd_idx][rd_ws] = ~m_bad[rd_idx][rd_ws];
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_ws == 2'd3) begin
        chk(cur_req, "data", rd_data, 32'h0);
        chk(cur_req, "tid", 32'(rd_tid), 32'h0);
        chk(cur_req, "perr", 32'(rd_perr), 32'h0);
      end else begin
        chk(cur_req, "data", rd_data, m_word[rd_idx][rd_ws]);
        chk(cur_req, "tid", 32'(rd_tid), rd_ws == 2'd0 ? 32'(m_tid[rd_idx]) : 32'h0);
        chk(cur_req, "perr", 32'(rd_perr), 32'(m_bad[rd_idx][rd_ws]));
      end
      chk(cur_req, "priv_fault", 32'(priv_fault), 32'(e_pf));
      chk(cur_req, "bad_form", 32'(bad_form), 32'(e_bf));
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic p, input logic [1:0] ws, input logic [31:0] ix,
                    input logic [31:0] s, input logic [TW-1:0] t);
    wr_en = 1'b1; priv = p; wr_ws = ws; ixop = ix; src = s; stid = t;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] i, input logic [1:0] ws);
    rd_idx = i; rd_ws = ws;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: got hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11: reset state
    #(CLK_PERIOD*2);
    for (int w = 0; w < 4; w++) begin
      rd_idx = 6'd17; rd_ws = 2'(w); #1;
      chk("R11", "rst data", rd_data, 32'h0);
      chk("R11", "rst perr", 32'(rd_perr), 32'h0);
    end
    chk("R11", "rst flags", {30'h0, bad_form, priv_fault}, 32'h0);
    @(negedge clk); rst_n = 1'b1; #1;

    cur_req = "R1";  wr(1, 2'd0, 32'hFFFF_FFC5, 32'hDEAD_BEEF, 8'hA5); rd(6'd5, 2'd0);
    cur_req = "R2";  wr(1, 2'd0, 32'h0000_003F, 32'h1234_5678, 8'h3C); rd(6'd63, 2'd0);
    cur_req = "R3";  wr(1, 2'd1, 32'h0000_0000, 32'hFFFF_FFFF, 8'h00); rd(6'd0, 2'd1);
    cur_req = "R4";  wr(1, 2'd2, 32'h0000_0000, 32'hFFFF_FFFF, 8'h00); rd(6'd0, 2'd2);
    cur_req = "R5";  rd(6'd0, 2'd0); rd(6'd5, 2'd1); rd(6'd5, 2'd2); rd(6'd4, 2'd0);
    cur_req = "R6";  wr(1, 2'd3, 32'h5, 32'h0, 8'hFF); rd(6'd5, 2'd3); rd(6'd5, 2'd0);
    cur_req = "R7";  wr(0, 2'd0, 32'h5, 32'h0, 8'h11); rd(6'd5, 2'd0);
    cur_req = "R7";  wr(0, 2'd3, 32'h5, 32'h0, 8'h11); rd(6'd5, 2'd0);
    cur_req = "R9";  rd(6'd9, 2'd1); wr(1, 2'd1, 32'h9, 32'hA5A5_5A5A, 8'h00); rd(6'd9, 2'd1);
    cur_req = "R10"; rd(6'd9, 2'd1); flip = 1'b1; tick(); flip = 1'b0; rd(6'd9, 2'd1);
    cur_req = "R10"; wr(1, 2'd1, 32'h9, 32'h0F0F_0F0F, 8'h00); rd(6'd9, 2'd1);
    cur_req = "R10"; flip = 1'b1; wr(1, 2'd2, 32'h9, 32'h1, 8'h00); flip = 1'b0; rd(6'd9, 2'd1);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      automatic int op = int'($urandom_range(0, 9));
      automatic logic [5:0] ri = 6'($urandom);
      rd_idx = (op == 9) ? 6'd63 : ri;
      rd_ws = 2'($urandom);
      flip = (op == 8);
      if (op < 6) begin
        cur_req = "R8";
        wr(1'($urandom_range(0, 6) != 0), 2'($urandom), $urandom, $urandom, 8'($urandom));
      end else begin
        cur_req = flip ? "R10" : "R5";
        tick();
      end
      flip = 1'b0;
    end
    wr_en = 1'b0;
    tick(); tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule